// File: doc/BRIEF.md
# Self-Alternating Stream Splitter

This block takes one stream of data tokens and deals them out over several output channels in a fixed rotating order. No select input is involved. An internal destination pointer decides where the next token goes. The pointer moves on only when a token has been fully delivered, so the order cannot be disturbed by timing on any channel. The unit serves as the fan-out half of a resource-sharing pair. A wide stream is split into parallel lanes, the lanes run through replicated operators, and a matching merger later joins the results again.

Every channel uses a four-phase request/acknowledge handshake that is level-based and return-to-zero, with the data bundled alongside the request. The splitter applies back-pressure to its producer by withholding its input acknowledge. That acknowledge is given only after the selected output has finished all four of its phases. A consumer that never answers therefore holds the producer indefinitely.

The default width is eight outputs. The outputs are numbered so that the sequence matches a balanced tree of two-way alternating splitters, read left to right. For that reason, output k receives tokens whose position modulo N, bit-reversed, equals k.

Top module: `stream_splitter`

## Requirements
- R1: During and after reset, all `out_req` bits and `in_ack` are 0. The first token accepted after reset goes to output 0.
- R2: With the default N_OUT=8, successive tokens go to outputs 0, 4, 2, 6, 1, 5, 3, 7 and then repeat. Output index = bit-reversed token count modulo N, which for N_OUT=2 gives plain alternation 0, 1, 0, 1.
- R3: At most one `out_req` bit is high at any time. While it is high, that channel's slice of `out_data` (bits [k*W +: W]) carries the token value that was on `in_data` when `in_req` was accepted.
- R4: The selected `out_req` stays high until its `out_ack` is seen high. It then falls in the following cycle.
- R5: `in_ack` rises only after the selected `out_ack` has returned to 0. It stays high while `in_req` remains high, and falls in the cycle after `in_req` is seen low.
- R6: While the selected output withholds its acknowledge, the splitter stalls. The same `out_req` stays high, `in_ack` stays 0, and no token is ever redirected to another output.
- R7: An `out_ack` asserted on any channel other than the selected one has no effect on `out_req`, `in_ack` or the token order.
- R8: Changes on `in_data` after a token has been accepted do not alter the value presented on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | Producer request, four-phase |
| in_data | input | W | Token value bundled with `in_req` |
| in_ack | output | 1 | Acknowledge to producer; high after the token has been delivered |
| out_req | output | N_OUT | Per-channel request, at most one high |
| out_ack | input | N_OUT | Per-channel acknowledge from consumers |
| out_data | output | N_OUT*W | Per-channel token value, channel k at bits [k*W +: W] |

## Verification
A table of sixteen distinct tokens is sent back to back. This walks the pointer twice around the bit-reversed cycle, which separates bit-reversed ordering from plain incrementing and from any off-by-one wrap. Directed tokens then hold back the selected acknowledge for many cycles, some while a foreign channel acknowledges, to tell a correct stall from skipping or from reacting to the wrong channel. A reset after three tokens separates a pointer that really returns to output 0 from one that only resets the handshake state. Each token also checks the exact cycle of the request fall and the acknowledge rise and fall, and the data is changed on the input in mid-handshake.

// File: rtl/split_pkg.sv
package split_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OUTHI = 2'd1,
    ST_OUTLO = 2'd2,
    ST_INACK = 2'd3
  } split_state_t;
endpackage

// File: rtl/split_ptr.sv
module split_ptr #(
  parameter int N_OUT = 8,
  localparam int PTR_W = $clog2(N_OUT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [PTR_W-1:0] sel,
  output logic [N_OUT-1:0] sel_oh
);
  logic [PTR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + 1'b1;
  end

  // leaf index of a balanced two-way tree: the root decision is the MSB
  for (genvar b = 0; b < PTR_W; b++) begin : g_rev
    assign sel[b] = cnt_q[PTR_W-1-b];
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_oh
    assign sel_oh[k] = (sel == PTR_W'(k));
  end

  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt_q));
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (cnt_q == PTR_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/split_fsm.sv
module split_fsm
  import split_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_req,
  input  logic ack_sel,
  output logic drive_req,
  output logic in_ack,
  output logic capture,
  output logic adv
);
  split_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (in_req)   st_d = ST_OUTHI;
      ST_OUTHI: if (ack_sel)  st_d = ST_OUTLO;
      ST_OUTLO: if (!ack_sel) st_d = ST_INACK;
      ST_INACK: if (!in_req)  st_d = ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign capture   = (st_q == ST_IDLE) && in_req;
  assign adv       = (st_q == ST_OUTLO) && !ack_sel;
  assign drive_req = (st_q == ST_OUTHI);
  assign in_ack    = (st_q == ST_INACK);

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_req && !ack_sel) |=> drive_req);
  p_inack_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> ($past(st_q) == ST_OUTLO));
  p_inack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && in_req) |=> in_ack);
endmodule

// File: rtl/split_lanes.sv
module split_lanes #(
  parameter int W     = 32,
  parameter int N_OUT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [W-1:0]       in_data,
  input  logic               drive_req,
  input  logic [N_OUT-1:0]   sel_oh,
  output logic [N_OUT-1:0]   out_req,
  output logic [N_OUT*W-1:0] out_data
);
  logic [W-1:0] tok_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       tok_q <= '0;
    else if (capture) tok_q <= in_data;
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_lane
    assign out_req[k]          = drive_req && sel_oh[k];
    assign out_data[k*W +: W]  = tok_q;
  end

  p_tok_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drive_req |-> !capture);
endmodule

// File: rtl/stream_splitter.sv
module stream_splitter #(
  parameter int W     = 32,
  parameter int N_OUT = 8,
  localparam int PTR_W = $clog2(N_OUT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_req,
  input  logic [W-1:0]       in_data,
  output logic               in_ack,
  output logic [N_OUT-1:0]   out_req,
  input  logic [N_OUT-1:0]   out_ack,
  output logic [N_OUT*W-1:0] out_data
);
  logic [PTR_W-1:0] sel;
  logic [N_OUT-1:0] sel_oh;
  logic             ack_sel, drive_req, capture, adv;

  assign ack_sel = out_ack[sel];

  split_ptr #(.N_OUT(N_OUT)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(adv), .sel(sel), .sel_oh(sel_oh));

  split_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .ack_sel(ack_sel),
    .drive_req(drive_req), .in_ack(in_ack), .capture(capture), .adv(adv));

  split_lanes #(.W(W), .N_OUT(N_OUT)) u_lanes (
    .clk(clk), .rst_n(rst_n), .capture(capture), .in_data(in_data),
    .drive_req(drive_req), .sel_oh(sel_oh), .out_req(out_req),
    .out_data(out_data));

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_req));
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|out_req) && !(|(out_req & out_ack))) |=> $stable(out_req));
  p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_req & out_ack)) |=> (out_req == '0));
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|out_req) && $past(|out_req)) |-> $stable(out_data));
  p_no_ack_while_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_req) |-> !in_ack);
endmodule

// File: tb/stream_splitter_bench.sv
module stream_splitter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int N = 8;
  localparam int NVEC = 16;
  localparam int WATCHDOG = 20000;

  localparam logic [W-1:0] VEC_DATA [NVEC] = '{
    32'h1111_0000, 32'h2222_0001, 32'h3333_0002, 32'h4444_0003,
    32'h5555_0004, 32'h6666_0005, 32'h7777_0006, 32'h8888_0007,
    32'hA5A5_0008, 32'h5A5A_0009, 32'hDEAD_000A, 32'hBEEF_000B,
    32'h0F0F_000C, 32'hF0F0_000D, 32'h1234_000E, 32'hFEDC_000F};
  localparam int VEC_CH [NVEC] = '{0,4,2,6,1,5,3,7,0,4,2,6,1,5,3,7};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_req = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ack;
  logic [N-1:0] out_req;
  logic [N-1:0] out_ack = '0;
  logic [N*W-1:0] out_data;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_splitter #(.W(W), .N_OUT(N)) u_stream_splitter (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_data(in_data),
    .in_ack(in_ack), .out_req(out_req), .out_ack(out_ack),
    .out_data(out_data));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_token(input logic [W-1:0] val, input int exp_ch,
                            input int stall, input bit foreign);
    int waited;
    @(negedge clk);
    in_req  = 1'b1;
    in_data = val;
    waited = 0;
    while (out_req == '0 && waited < 50) begin
      @(negedge clk);
      waited++;
    end
    chk(out_req == N'(1) << exp_ch, "R2", "selected channel", out_req,
        N'(1) << exp_ch);
    chk(out_data[exp_ch*W +: W] == val, "R3", "lane data",
        out_data[exp_ch*W +: W], val);
    chk(in_ack == 1'b0, "R5", "early in_ack", in_ack, 0);
    in_data = ~val;  // R8: input moves after acceptance
    for (int s = 0; s < stall; s++) begin
      if (foreign) out_ack[(exp_ch + 1) % N] = 1'b1;  // R7
      @(negedge clk);
      chk(out_req == N'(1) << exp_ch && in_ack == 1'b0, foreign ? "R7" : "R6",
          "stall hold", {in_ack, out_req}, N'(1) << exp_ch);
    end
    out_ack = '0;
    chk(out_data[exp_ch*W +: W] == val, "R8", "data after input change",
        out_data[exp_ch*W +: W], val);
    out_ack[exp_ch] = 1'b1;
    @(negedge clk);
    chk(out_req == '0, "R4", "req fall after ack", out_req, 0);
    chk(in_ack == 1'b0, "R5", "in_ack before ack low", in_ack, 0);
    out_ack[exp_ch] = 1'b0;
    @(negedge clk);
    chk(in_ack == 1'b1, "R5", "in_ack rise", in_ack, 1);
    @(negedge clk);
    chk(in_ack == 1'b1 && out_req == '0, "R5", "in_ack hold",
        {in_ack, out_req}, {1'b1, N'(0)});
    in_req = 1'b0;
    @(negedge clk);
    chk(in_ack == 1'b0, "R5", "in_ack fall", in_ack, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_req == '0 && in_ack == 1'b0, "R1", "during reset",
        {in_ack, out_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_req == '0 && in_ack == 1'b0, "R1", "after reset",
        {in_ack, out_req}, 0);
    // an idle acknowledge must not disturb anything (R7)
    out_ack = 8'hFF;
    @(negedge clk);
    chk(out_req == '0 && in_ack == 1'b0, "R7", "idle ack", {in_ack, out_req}, 0);
    out_ack = '0;

    for (int i = 0; i < NVEC; i++) begin
      send_token(VEC_DATA[i], VEC_CH[i], 0, 1'b0);  // R2 order table
    end

    send_token(32'hCAFE_0100, 0, 25, 1'b0);   // R6 long stall
    send_token(32'hCAFE_0101, 4, 10, 1'b1);   // R7 foreign ack during stall
    send_token(32'hCAFE_0102, 2, 3, 1'b1);    // R7, order intact

    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_req == '0 && in_ack == 1'b0, "R1", "mid-stream reset",
        {in_ack, out_req}, 0);
    rst_n = 1'b1;
    send_token(32'h0BAD_F00D, 0, 0, 1'b0);    // R1 first after reset
    send_token(32'h0BAD_F00E, 4, 0, 1'b0);    // R2 restart of sequence

    finish_run();
  end
endmodule